// File: doc/BRIEF.md
# Hall-Locked Three-Phase Sine Duty Generator

This block produces three sinusoidal duty-cycle words for a PWM timer that drives a permanent-magnet AC motor. The words are spaced a third of a turn apart. The motor carries a single Hall sensor. A 16-bit electrical angle advances once per update tick, and every Hall edge snaps that angle to a programmable advance angle. The edge polarity picks between that angle and the angle half a turn later. The Hall half-period, measured outside the block and counted in update ticks, sets the step size for the following half-period.

Each phase reads a computed 256-entry sine table twice: once at the angle and once at three times the angle. This adds a third harmonic at one sixth of the fundamental, which widens the usable line-to-line voltage. The result is scaled by an amplitude. That amplitude is the smaller of two values: the command, and a voltage-per-frequency ceiling that grows with the present step size. The result is then centred on half the timer range.

Update ticks fall on every second PWM overflow. Until a full Hall half-period has been seen after reset, the three outputs rest at mid-scale.

Top module: `hall_sine_mod`

## Requirements
- R1: After reset, `duty_a`, `duty_b` and `duty_c` equal floor(PWM_TOP/2) and `duty_load` is low. They stay at floor(PWM_TOP/2) at every update until the second Hall edge after reset. The first edge only marks the start of a half-period.
- R2: Update ticks fall on every second `pwm_ovf` pulse, counted from reset. The duty words change only in the cycle after an update tick, and `duty_load` is high for exactly that one cycle.
- R3: At each Hall edge after the first, the step becomes floor(32768 / n). Here n is `half_ticks`, limited from below as in R4. At every update tick the angle that was just used for the duty words is then advanced by the step, modulo 65536.
- R4: A `half_ticks` value below 9, including 0, is treated as 9. The step therefore never exceeds 3640, which keeps at least 18 updates per electrical cycle.
- R5: A rising Hall edge (`hall_rise`=1) loads the angle with the advance angle. A falling edge loads the advance angle plus 32768, modulo 65536. When an edge and an update tick share a cycle, the load wins and the angle is not advanced.
- R6: The advance angle is `adv_offset` + floor(`adv_slope` × step / 256), modulo 65536. It uses the step computed at the same edge.
- R7: Phase A uses the angle θ. Phase B uses θ − 21845 and phase C uses θ − 43691, both modulo 65536. The table index is the top 8 bits of the phase angle, and 256 indices make one electrical turn.
- R8: For table index i, let x = 2πi/256 and let a be the amplitude. Each duty is within 2 counts of floor(PWM_TOP/2) + 2047·(sin x + sin(3x)/6)·a·PWM_TOP / 2^24.
- R9: The amplitude is min(`amp_cmd`, min(4095, `vf_base` + floor(`vf_slope` × step / 256))).
- R10: Every duty word stays between 0 and PWM_TOP inclusive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_ovf | input | 1 | One-cycle pulse at each PWM period end |
| hall_edge | input | 1 | One-cycle pulse at each Hall transition |
| hall_rise | input | 1 | Polarity of the transition, 1 = rising |
| half_ticks | input | HALF_W (16) | Measured Hall half-period in update ticks |
| amp_cmd | input | AMP_W (12) | Requested amplitude, 4095 ≈ full |
| adv_offset | input | ANG_W (16) | Advance angle at zero speed |
| adv_slope | input | SLOPE_W (8) | Advance angle gain versus step, /256 |
| vf_base | input | AMP_W (12) | Amplitude ceiling at zero speed |
| vf_slope | input | SLOPE_W (8) | Amplitude ceiling gain versus step, /256 |
| duty_a | output | DUTY_W (10) | Phase A duty word |
| duty_b | output | DUTY_W (10) | Phase B duty word |
| duty_c | output | DUTY_W (10) | Phase C duty word |
| duty_load | output | 1 | High for the cycle in which new duty words appear |

## Verification
The bench keeps every default: a 16-bit angle, a 256-entry table of ±2047, a 512-count timer and a floor of 9 ticks per half-period. The 512-count range makes a full-amplitude swing of about ±220 counts, so table, harmonic and scaling errors show up well outside the two-count tolerance. The 16-bit `half_ticks` lets the bench drive 0 and 4, below the floor, and 64 and 100, above it. Slopes at 255 and 8 push the advance and the voltage-per-frequency ceiling far enough to change the table index and the amplitude by clear amounts.

// File: rtl/hall_sine_mod.sv
module hall_sine_mod #(
  parameter int ANG_W    = 16,
  parameter int HALF_W   = 16,
  parameter int AMP_W    = 12,
  parameter int SLOPE_W  = 8,
  parameter int LUT_BITS = 8,
  parameter int SIN_AMP  = 2047,
  parameter int MIN_HALF = 9,
  parameter int PWM_TOP  = 512,
  localparam int DUTY_W  = $clog2(PWM_TOP + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pwm_ovf,
  input  logic               hall_edge,
  input  logic               hall_rise,
  input  logic [HALF_W-1:0]  half_ticks,
  input  logic [AMP_W-1:0]   amp_cmd,
  input  logic [ANG_W-1:0]   adv_offset,
  input  logic [SLOPE_W-1:0] adv_slope,
  input  logic [AMP_W-1:0]   vf_base,
  input  logic [SLOPE_W-1:0] vf_slope,
  output logic [DUTY_W-1:0]  duty_a,
  output logic [DUTY_W-1:0]  duty_b,
  output logic [DUTY_W-1:0]  duty_c,
  output logic               duty_load
);

  localparam int N_LUT    = 1 << LUT_BITS;
  localparam int HALF_LUT = N_LUT / 2;
  localparam int SIN_W    = $clog2(SIN_AMP + 1) + 1;
  localparam int HALF_TURN_I = 2 ** (ANG_W - 1);
  localparam logic [ANG_W-1:0] HALF_TURN = {1'b1, {(ANG_W-1){1'b0}}};
  localparam logic [ANG_W-1:0] OFF_B = ANG_W'((2 ** ANG_W) / 3);
  localparam logic [ANG_W-1:0] OFF_C = ANG_W'((2 ** (ANG_W + 1) + 1) / 3);
  localparam int AMP_MAX  = 2 ** AMP_W - 1;
  localparam int MID      = PWM_TOP / 2;
  localparam int SCALE_SH = SIN_W + AMP_W;
  localparam int PROD_W   = SIN_W + AMP_W + DUTY_W + 8;
  localparam int WIDE_W   = SLOPE_W + ANG_W;
  localparam logic [ANG_W-1:0] PH_OFF [3] = '{'0, OFF_B, OFF_C};

  // Parabolic-ratio sine approximation, evaluated at elaboration.
  function automatic int sine_at(int i);
    longint p, q, num, den, v;
    p   = longint'(i % HALF_LUT);
    q   = longint'(HALF_LUT) - p;
    num = 4 * longint'(SIN_AMP) * p * q;
    den = (5 * longint'(HALF_LUT) * longint'(HALF_LUT)) / 4 - p * q;
    v   = (2 * num + den) / (2 * den);
    if (i >= HALF_LUT) v = -v;
    return int'(v);
  endfunction

  logic signed [SIN_W-1:0] lut [N_LUT];
  for (genvar g = 0; g < N_LUT; g++) begin : g_lut
    assign lut[g] = SIN_W'(sine_at(g));
  end

  logic              toggle, seen_edge, locked;
  logic [ANG_W-1:0]  acc, inc;
  logic [DUTY_W-1:0] duty_q [3];
  logic [DUTY_W-1:0] duty_n [3];

  wire update = pwm_ovf & toggle;

  wire [HALF_W-1:0] n_eff = (half_ticks < HALF_W'(MIN_HALF)) ? HALF_W'(MIN_HALF) : half_ticks;
  wire [ANG_W-1:0]  inc_new = ANG_W'(32'(HALF_TURN_I) / 32'(n_eff));

  wire [WIDE_W-1:0] adv_prod = WIDE_W'(adv_slope) * WIDE_W'(inc_new);
  wire [ANG_W-1:0]  phi      = adv_offset + ANG_W'(adv_prod >> 8);
  wire [ANG_W-1:0]  load_ang = hall_rise ? phi : phi + HALF_TURN;

  wire [WIDE_W-1:0] vf_prod = WIDE_W'(vf_slope) * WIDE_W'(inc);
  wire [WIDE_W:0]   vf_sum  = (WIDE_W+1)'(vf_base) + (WIDE_W+1)'(vf_prod >> 8);
  wire [AMP_W-1:0]  amp_lim = (vf_sum > (WIDE_W+1)'(AMP_MAX)) ? AMP_W'(AMP_MAX) : AMP_W'(vf_sum);
  wire [AMP_W-1:0]  amp_eff = (amp_cmd < amp_lim) ? amp_cmd : amp_lim;

  for (genvar ph = 0; ph < 3; ph++) begin : g_ph
    logic [ANG_W-1:0]        ang;
    logic [LUT_BITS-1:0]     idx1, idx3;
    logic signed [SIN_W:0]   wave;
    logic signed [PROD_W-1:0] prod, dval;
    assign ang  = acc - PH_OFF[ph];
    assign idx1 = ang[ANG_W-1 -: LUT_BITS];
    assign idx3 = LUT_BITS'(3 * idx1);
    assign wave = (SIN_W+1)'(lut[idx1]) + (SIN_W+1)'(lut[idx3] / 6);
    assign prod = PROD_W'(wave) * PROD_W'($signed({1'b0, amp_eff})) * PROD_W'(PWM_TOP);
    assign dval = PROD_W'(MID) + (prod >>> SCALE_SH);
    assign duty_n[ph] = DUTY_W'(dval);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      toggle    <= 1'b0;
      seen_edge <= 1'b0;
      locked    <= 1'b0;
      acc       <= '0;
      inc       <= '0;
      duty_load <= 1'b0;
      for (int i = 0; i < 3; i++) duty_q[i] <= DUTY_W'(MID);
    end else begin
      if (pwm_ovf) toggle <= ~toggle;
      duty_load <= update;
      if (hall_edge) seen_edge <= 1'b1;
      if (hall_edge && seen_edge) begin
        locked <= 1'b1;
        inc    <= inc_new;
        acc    <= load_ang;
      end else if (update) begin
        acc <= acc + inc;
      end
      if (update)
        for (int i = 0; i < 3; i++) duty_q[i] <= locked ? duty_n[i] : DUTY_W'(MID);
    end
  end

  assign duty_a = duty_q[0];
  assign duty_b = duty_q[1];
  assign duty_c = duty_q[2];

endmodule

// File: rtl/hall_sine_mod_chk.sv
module hall_sine_mod_chk #(
  parameter int PWM_TOP  = 512,
  parameter int DUTY_W   = 10,
  parameter int ANG_W    = 16,
  parameter int MIN_HALF = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pwm_ovf,
  input logic              hall_edge,
  input logic              duty_load,
  input logic [DUTY_W-1:0] duty_a,
  input logic [DUTY_W-1:0] duty_b,
  input logic [DUTY_W-1:0] duty_c,
  input logic [ANG_W-1:0]  inc
);
  localparam logic [DUTY_W-1:0] MID = DUTY_W'(PWM_TOP / 2);
  localparam logic [DUTY_W-1:0] TOP = DUTY_W'(PWM_TOP);
  localparam logic [ANG_W-1:0]  INC_CAP = ANG_W'((2 ** (ANG_W - 1)) / MIN_HALF);

  logic       par;
  logic [1:0] edges;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par   <= 1'b0;
      edges <= '0;
    end else begin
      if (pwm_ovf) par <= ~par;
      if (hall_edge && edges != 2'd2) edges <= edges + 2'd1;
    end
  end

  p_mid_unlocked_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (edges < 2'd2) |-> (duty_a == MID && duty_b == MID && duty_c == MID));
  p_load_cadence_r2: assert property (@(posedge clk) disable iff (!rst_n)
    duty_load |-> $past(pwm_ovf && par));
  p_load_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    duty_load |=> !duty_load);
  p_hold_between_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !duty_load |-> ($stable(duty_a) && $stable(duty_b) && $stable(duty_c)));
  p_step_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    inc <= INC_CAP);
  p_in_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_a <= TOP && duty_b <= TOP && duty_c <= TOP));
endmodule

bind hall_sine_mod hall_sine_mod_chk #(
  .PWM_TOP(PWM_TOP), .DUTY_W(DUTY_W), .ANG_W(ANG_W), .MIN_HALF(MIN_HALF)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pwm_ovf(pwm_ovf), .hall_edge(hall_edge),
  .duty_load(duty_load), .duty_a(duty_a), .duty_b(duty_b), .duty_c(duty_c),
  .inc(inc)
);

// File: tb/hall_sine_mod_bench.sv
`timescale 1ns/1ps
module hall_sine_mod_bench;
  localparam int TOP = 512;
  localparam int MID = TOP / 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pwm_ovf = 1'b0, hall_edge = 1'b0, hall_rise = 1'b0;
  logic [15:0] half_ticks = '0;
  logic [11:0] amp_cmd = 12'd4095, vf_base = 12'd4095;
  logic [15:0] adv_offset = '0;
  logic [7:0]  adv_slope = '0, vf_slope = '0;
  logic [9:0]  duty_a, duty_b, duty_c;
  logic        duty_load;
  int checks = 0, failures = 0, cyc = 0;

  always #2 clk = ~clk;

  hall_sine_mod u_hall_sine_mod (
    .clk(clk), .rst_n(rst_n), .pwm_ovf(pwm_ovf), .hall_edge(hall_edge),
    .hall_rise(hall_rise), .half_ticks(half_ticks), .amp_cmd(amp_cmd),
    .adv_offset(adv_offset), .adv_slope(adv_slope), .vf_base(vf_base),
    .vf_slope(vf_slope), .duty_a(duty_a), .duty_b(duty_b), .duty_c(duty_c),
    .duty_load(duty_load)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      failures++;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected<=20000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check_int(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic real exp_duty(input int theta, input int amp);
    int  idx;
    real x, s;
    idx = (theta & 16'hffff) >> 8;
    x   = 2.0 * 3.14159265358979 * idx / 256.0;
    s   = 2047.0 * ($sin(x) + $sin(3.0 * x) / 6.0);
    return MID + s * amp * TOP / 16777216.0;
  endfunction

  task automatic check_near(input string tag, input int act, input real exp);
    real d;
    checks++;
    d = act - exp;
    if (d > 2.0 || d < -2.0) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0.2f", tag, act, exp);
    end
  endtask

  task automatic expect_phases(input string tag, input int theta, input int amp);
    check_near({tag, " phase A"}, int'(duty_a), exp_duty(theta, amp));
    check_near({tag, " phase B"}, int'(duty_b), exp_duty(theta - 21845, amp));
    check_near({tag, " phase C"}, int'(duty_c), exp_duty(theta - 43691, amp));
    checks++;
    if (duty_a > 10'(TOP) || duty_b > 10'(TOP) || duty_c > 10'(TOP)) begin
      failures++;
      $display("FAIL R10: actual=%0d/%0d/%0d expected<=%0d", duty_a, duty_b, duty_c, TOP);
    end
  endtask

  task automatic tick();
    @(negedge clk) pwm_ovf = 1'b1;
    @(negedge clk) pwm_ovf = 1'b0;
  endtask

  task automatic update();
    tick();
    tick();
  endtask

  task automatic hall(input bit rise, input int n);
    @(negedge clk);
    hall_edge = 1'b1; hall_rise = rise; half_ticks = 16'(n);
    @(negedge clk) hall_edge = 1'b0;
  endtask

  task automatic t_reset();
    check_int("R1 reset duty_a", int'(duty_a), MID);
    check_int("R1 reset duty_b", int'(duty_b), MID);
    check_int("R1 reset duty_c", int'(duty_c), MID);
    check_int("R1 reset duty_load", int'(duty_load), 0);
  endtask

  task automatic t_cadence();
    tick();
    check_int("R2 no load after one overflow", int'(duty_load), 0);
    tick();
    check_int("R2 load after second overflow", int'(duty_load), 1);
    check_int("R1 unlocked mid", int'(duty_a), MID);
    @(negedge clk);
    check_int("R2 load lasts one cycle", int'(duty_load), 0);
    hall(1'b1, 64);
    update();
    check_int("R1 first edge only anchors A", int'(duty_a), MID);
    check_int("R1 first edge only anchors C", int'(duty_c), MID);
  endtask

  task automatic t_track();
    adv_offset = 16'h1000;
    hall(1'b1, 64);
    for (int k = 0; k < 4; k++) begin
      update();
      expect_phases("R3 R7 R8 step 512", 16'h1000 + 512 * k, 4095);
    end
  endtask

  task automatic t_fall();
    adv_offset = 16'h2000;
    hall(1'b0, 100);
    for (int k = 0; k < 2; k++) begin
      update();
      expect_phases("R5 falling edge", 16'hA000 + 327 * k, 4095);
    end
  endtask

  task automatic t_clamp();
    adv_offset = 16'h0000;
    hall(1'b1, 4);
    for (int k = 0; k < 3; k++) begin
      update();
      expect_phases("R4 short half-period", 3640 * k, 4095);
    end
    hall(1'b1, 0);
    update();
    update();
    expect_phases("R4 zero half-period", 3640, 4095);
  endtask

  task automatic t_advance();
    adv_offset = 16'h0000;
    adv_slope  = 8'd255;
    hall(1'b1, 16);
    for (int k = 0; k < 2; k++) begin
      update();
      expect_phases("R6 speed advance", 2040 + 2048 * k, 4095);
    end
    adv_slope = 8'd0;
  endtask

  task automatic t_vf();
    adv_offset = 16'h4000;
    vf_base    = 12'd1000;
    vf_slope   = 8'd8;
    hall(1'b1, 64);
    update();
    expect_phases("R9 ceiling limits", 16'h4000, 1016);
    amp_cmd = 12'd500;
    update();
    expect_phases("R9 command below ceiling", 16'h4200, 500);
    amp_cmd  = 12'd4095;
    vf_base  = 12'd4095;
    vf_slope = 8'd0;
  endtask

  task automatic t_coincide();
    adv_offset = 16'h3000;
    tick();
    @(negedge clk);
    pwm_ovf = 1'b1; hall_edge = 1'b1; hall_rise = 1'b1; half_ticks = 16'd64;
    @(negedge clk);
    pwm_ovf = 1'b0; hall_edge = 1'b0;
    check_int("R2 load on shared cycle", int'(duty_load), 1);
    update();
    expect_phases("R5 load beats advance", 16'h3000, 4095);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cadence();
    t_track();
    t_fall();
    t_clamp();
    t_advance();
    t_vf();
    t_coincide();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule